// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. A requester (normally the translation lookaside buffer) hands it a virtual page number and then stays suspended until the walker returns a result. The walker first reads a directory entry from a first-level table. It forms that address from a table base register plus the upper ten bits of the page number, scaled to a word. If that entry is marked present, its upper bits name a second-level table. The walker reads that table at the lower ten bits of the page number. The second entry supplies the physical frame number and the access attributes.

Every walk is a chain of two dependent reads through a single-outstanding request/response port whose latency has no upper bound. An entry whose present bit is clear at either level ends the walk at once with a fault result. The table base register is rewritten whenever the running process changes. Each such write produces a one-cycle flush pulse for the translation cache, and it cancels any walk in flight. If a read of the cancelled walk is still outstanding, its response is swallowed before the next walk may begin.

Top module: `xlat_walker`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, rsp_valid and flush are all 0.
- R2: A miss accepted on a clock edge (miss_valid and miss_ready high, base_wr low) raises mem_req_valid in the next cycle, with mem_req_addr = table base + 4 * miss_vpn[19:10].
- R3: While mem_req_valid is high and mem_req_ready is low, the request stays valid and mem_req_addr does not change.
- R4: When a first-level entry returns with bit 0 set, the next read goes to {entry[31:12], 12'h000} + 4 * miss_vpn[9:0].
- R5: When a second-level entry returns with bit 0 set, rsp_valid is high for exactly the next cycle, with rsp_ppn = entry[31:12], rsp_attr = entry[4:1] and rsp_fault = 0.
- R6: A first-level entry with bit 0 clear ends the walk with rsp_fault = 1, rsp_ppn = 0 and rsp_attr = 0, and issues no second read.
- R7: A second-level entry with bit 0 clear ends the walk with rsp_fault = 1, rsp_ppn = 0 and rsp_attr = 0, after exactly two reads.
- R8: The walker waits for any number of cycles for a response and never has more than one read outstanding.
- R9: A write of the table base (base_wr high) gives flush = 1 in the following cycle only, and walks that start later use the new base.
- R10: A base write during a walk cancels it. No rsp_valid and no further read follows for that walk. A response still owed for it is discarded, and miss_ready stays 0 until that response has arrived.
- R11: miss_ready is 0 from the cycle after a miss is accepted until the walk's result has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr | input | 1 | Write strobe for the first-level table base |
| base_wdata | input | 32 | New first-level table base (page aligned) |
| flush | output | 1 | One-cycle pulse after every base write |
| miss_valid | input | 1 | Requester has a page number to translate |
| miss_vpn | input | 20 | Virtual page number (upper field indexes level one) |
| miss_ready | output | 1 | Walker is free to accept a miss |
| rsp_valid | output | 1 | Walk result present for one cycle |
| rsp_ppn | output | 20 | Physical frame number |
| rsp_attr | output | 4 | Attribute bits taken from entry bits 4..1 |
| rsp_fault | output | 1 | A non-present entry ended the walk |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page table entry returned |

## Verification
The bench uses the highest index in both fields. A walker that dropped an index bit or failed to scale by four would read from the wrong address. It pairs a long response latency with a request that is held off for several cycles. An engine that gave up early, let its address drift, or sent the second read before the first returned would show the wrong address, a second outstanding read, or an unstable request. Absent entries at each level expose a walker that carries on past a fault or leaks stale frame bits into the result. A base write while a read is pending checks two things: that the late response is not mistaken for data of the next walk, and that no result escapes for the cancelled one.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WK_IDLE    = 3'd0,
      WK_L1_REQ  = 3'd1,
      WK_L1_WAIT = 3'd2,
      WK_L2_REQ  = 3'd3,
      WK_L2_WAIT = 3'd4,
      WK_DONE    = 3'd5
   } walk_state_e;

   function automatic logic is_wait(walk_state_e s);
      return (s == WK_L1_WAIT) || (s == WK_L2_WAIT);
   endfunction

   function automatic logic is_req(walk_state_e s);
      return (s == WK_L1_REQ) || (s == WK_L2_REQ);
   endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
   parameter int PA_W       = 32,
   parameter int OFS_W      = 12,
   parameter bit ALIGN_BASE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [PA_W-1:0] wdata,
   output logic [PA_W-1:0] base,
   output logic            flush
);
   localparam logic [PA_W-1:0] PAGE_MASK = ~((PA_W'(1) << OFS_W) - PA_W'(1));

   logic [PA_W-1:0] base_q;
   logic            flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= wr;
         if (wr) base_q <= wdata;
      end
   end

   generate
      if (ALIGN_BASE) begin : g_aligned
         assign base = base_q & PAGE_MASK;
      end else begin : g_raw
         assign base = base_q;
      end
   endgenerate

   assign flush = flush_q;

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W       = 32,
   parameter int OFS_W      = 12,
   parameter int L1_W       = 10,
   parameter int L2_W       = 10,
   parameter bit ALIGN_BASE = 1'b1
) (
   input  logic            sel_l2,
   input  logic [PA_W-1:0] l1_base,
   input  logic [PA_W-1:0] l2_base,
   input  logic [L1_W-1:0] l1_idx,
   input  logic [L2_W-1:0] l2_idx,
   output logic [PA_W-1:0] addr
);
   localparam bit L1_OR = ALIGN_BASE && ((L1_W + 2) <= OFS_W);
   localparam bit L2_OR = (L2_W + 2) <= OFS_W;

   logic [PA_W-1:0] off1, off2, a1, a2;

   assign off1 = PA_W'({l1_idx, 2'b00});
   assign off2 = PA_W'({l2_idx, 2'b00});

   generate
      if (L1_OR) begin : g_l1_merge
         assign a1 = l1_base | off1;
      end else begin : g_l1_add
         assign a1 = l1_base + off1;
      end
      if (L2_OR) begin : g_l2_merge
         assign a2 = l2_base | off2;
      end else begin : g_l2_add
         assign a2 = l2_base + off2;
      end
   endgenerate

   assign addr = sel_l2 ? a2 : a1;

endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec #(
   parameter int ENT_W  = 32,
   parameter int OFS_W  = 12,
   parameter int ATTR_W = 4
) (
   input  logic [ENT_W-1:0]       ent,
   output logic                   present,
   output logic [ENT_W-OFS_W-1:0] frame,
   output logic [ATTR_W-1:0]      attr
);
   assign present = ent[0];
   assign frame   = ent[ENT_W-1:OFS_W];
   assign attr    = ent[ATTR_W:1];

   generate
      if (ATTR_W + 1 < OFS_W) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^ent[OFS_W-1:ATTR_W+1];
      end
   endgenerate

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import ptw_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int L1_W       = 10,
   parameter int L2_W       = 10,
   parameter int OFS_W      = 12,
   parameter int PA_W       = 32,
   parameter int ATTR_W     = 4,
   parameter bit ALIGN_BASE = 1'b1,
   localparam int VPN_W     = L1_W + L2_W,
   localparam int PPN_W     = PA_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr,
   input  logic [PA_W-1:0]   base_wdata,
   output logic              flush,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   output logic              miss_ready,
   output logic              rsp_valid,
   output logic [PPN_W-1:0]  rsp_ppn,
   output logic [ATTR_W-1:0] rsp_attr,
   output logic              rsp_fault,
   output logic              mem_req_valid,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [PA_W-1:0]   mem_rsp_data
);
   generate
      if (VA_W != L1_W + L2_W + OFS_W) begin : g_bad_split
         $error("xlat_walker: index and offset fields must cover VA_W");
      end
      if (ATTR_W + 1 > OFS_W) begin : g_bad_attr
         $error("xlat_walker: attribute bits must sit below the frame field");
      end
      if (PA_W < L1_W + 2 || PA_W < L2_W + 2) begin : g_bad_pa
         $error("xlat_walker: physical address too narrow for table index");
      end
   endgenerate

   walk_state_e state_q, state_d;

   logic [PA_W-1:0]   base;
   logic [VPN_W-1:0]  vpn_q;
   logic [PPN_W-1:0]  l2_frame_q;
   logic [PPN_W-1:0]  ppn_q;
   logic [ATTR_W-1:0] attr_q;
   logic              fault_q;
   logic              stale_q;

   logic              pte_present;
   logic [PPN_W-1:0]  pte_frame;
   logic [ATTR_W-1:0] pte_attr;

   logic accept, handshake, drop_pending;

   ptw_base_reg #(.PA_W(PA_W), .OFS_W(OFS_W), .ALIGN_BASE(ALIGN_BASE)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (base_wr),
      .wdata (base_wdata),
      .base  (base),
      .flush (flush)
   );

   ptw_addr_gen #(
      .PA_W(PA_W), .OFS_W(OFS_W), .L1_W(L1_W), .L2_W(L2_W), .ALIGN_BASE(ALIGN_BASE)
   ) u_addr (
      .sel_l2  (state_q == WK_L2_REQ),
      .l1_base (base),
      .l2_base ({l2_frame_q, {OFS_W{1'b0}}}),
      .l1_idx  (vpn_q[VPN_W-1:L2_W]),
      .l2_idx  (vpn_q[L2_W-1:0]),
      .addr    (mem_req_addr)
   );

   ptw_pte_dec #(.ENT_W(PA_W), .OFS_W(OFS_W), .ATTR_W(ATTR_W)) u_dec (
      .ent     (mem_rsp_data),
      .present (pte_present),
      .frame   (pte_frame),
      .attr    (pte_attr)
   );

   assign miss_ready    = (state_q == WK_IDLE) && !stale_q;
   assign accept        = miss_valid && miss_ready && !base_wr;
   assign mem_req_valid = is_req(state_q);
   assign handshake     = mem_req_valid && mem_req_ready;

   // A cancelled walk still owes a response if its read was accepted.
   assign drop_pending = base_wr &&
                         ((is_wait(state_q) && !mem_rsp_valid) ||
                          (is_req(state_q) && mem_req_ready));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WK_IDLE:    if (accept) state_d = WK_L1_REQ;
         WK_L1_REQ:  if (handshake) state_d = WK_L1_WAIT;
         WK_L1_WAIT: if (mem_rsp_valid) state_d = pte_present ? WK_L2_REQ : WK_DONE;
         WK_L2_REQ:  if (handshake) state_d = WK_L2_WAIT;
         WK_L2_WAIT: if (mem_rsp_valid) state_d = WK_DONE;
         WK_DONE:    state_d = WK_IDLE;
         default:    state_d = WK_IDLE;
      endcase
      if (base_wr) state_d = WK_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= WK_IDLE;
         stale_q    <= 1'b0;
         vpn_q      <= '0;
         l2_frame_q <= '0;
         ppn_q      <= '0;
         attr_q     <= '0;
         fault_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (drop_pending)                  stale_q <= 1'b1;
         else if (stale_q && mem_rsp_valid) stale_q <= 1'b0;
         if (accept) vpn_q <= miss_vpn;
         if (state_q == WK_L1_WAIT && mem_rsp_valid) begin
            l2_frame_q <= pte_frame;
            if (!pte_present) begin
               fault_q <= 1'b1;
               ppn_q   <= '0;
               attr_q  <= '0;
            end
         end
         if (state_q == WK_L2_WAIT && mem_rsp_valid) begin
            fault_q <= !pte_present;
            ppn_q   <= pte_present ? pte_frame : '0;
            attr_q  <= pte_present ? pte_attr  : '0;
         end
      end
   end

   assign rsp_valid = (state_q == WK_DONE) && !base_wr;
   assign rsp_ppn   = ppn_q;
   assign rsp_attr  = attr_q;
   assign rsp_fault = fault_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int PA_W   = 32,
   parameter int PPN_W  = 20,
   parameter int ATTR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              base_wr,
   input logic              flush,
   input logic              miss_valid,
   input logic              miss_ready,
   input logic              rsp_valid,
   input logic [PPN_W-1:0]  rsp_ppn,
   input logic [ATTR_W-1:0] rsp_attr,
   input logic              rsp_fault,
   input logic              mem_req_valid,
   input logic [PA_W-1:0]   mem_req_addr,
   input logic              mem_req_ready,
   input logic              mem_rsp_valid
);
   logic [1:0] outs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outs_q <= '0;
      else if ((mem_req_valid && mem_req_ready) && !mem_rsp_valid) outs_q <= outs_q + 2'd1;
      else if (!(mem_req_valid && mem_req_ready) && mem_rsp_valid && outs_q != 0)
         outs_q <= outs_q - 2'd1;
   end

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && !base_wr) |=> (mem_req_valid && mem_req_addr[1:0] == 2'b00));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready && !base_wr) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_fault_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_ppn == '0 && rsp_attr == '0));

   p_single_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (outs_q == 2'd0));

   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> flush);

   p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> (!rsp_valid && !mem_req_valid));

   p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || rsp_valid) |-> !miss_ready);

endmodule

bind xlat_walker xlat_walker_chk #(.PA_W(PA_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .base_wr       (base_wr),
   .flush         (flush),
   .miss_valid    (miss_valid),
   .miss_ready    (miss_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ppn       (rsp_ppn),
   .rsp_attr      (rsp_attr),
   .rsp_fault     (rsp_fault),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        flush;
   logic        miss_valid = 1'b0;
   logic [19:0] miss_vpn = '0;
   logic        miss_ready;
   logic        rsp_valid;
   logic [19:0] rsp_ppn;
   logic [3:0]  rsp_attr;
   logic        rsp_fault;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   xlat_walker u_xlat_walker (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model
   logic [31:0] mem [logic [31:0]];
   int          lat = 0;
   int          gap = 0;
   int          gap_cnt = 0;
   int          wait_cnt = 0;
   bit          pend = 1'b0;
   logic [31:0] paddr = '0;
   logic [31:0] first_addr = '0;
   int          req_cnt = 0;
   logic [31:0] req_log [4];
   int          overlap_err = 0;
   int          stab_err = 0;
   int          rsp_cnt = 0;

   function automatic logic [31:0] rd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
         mem_req_ready = 1'b0;
         if (mem_req_valid) overlap_err++;
         if (wait_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(paddr);
            pend = 1'b0;
         end else wait_cnt--;
      end else if (mem_req_valid && !mem_req_ready) begin
         if (gap_cnt == 0) first_addr = mem_req_addr;
         if (gap_cnt >= gap) begin
            if (mem_req_addr != first_addr) stab_err++;
            mem_req_ready = 1'b1;
            pend = 1'b1;
            paddr = mem_req_addr;
            wait_cnt = lat;
            gap_cnt = 0;
            req_log[req_cnt % 4] = mem_req_addr;
            req_cnt++;
         end else gap_cnt++;
      end else mem_req_ready = 1'b0;
      if (rsp_valid) rsp_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pte(logic [19:0] frame, logic [3:0] attr, bit present);
      return {frame, 7'd0, attr, present};
   endfunction

   task automatic walk(input logic [31:0] tbase, input logic [19:0] vpn,
                       input int exp_reqs, input logic [19:0] exp_ppn,
                       input logic [3:0] exp_attr, input bit exp_fault, input string tag);
      int start;
      bit got;
      logic [31:0] a1, a2;
      start = req_cnt;
      got = 1'b0;
      a1 = tbase + {20'd0, vpn[19:10], 2'b00};
      a2 = {rd(a1)[31:12], 12'h000} + {20'd0, vpn[9:0], 2'b00};
      @(negedge clk);
      miss_vpn = vpn;
      miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
      chk(!miss_ready, {tag, " R11 busy after accept"}, {31'd0, miss_ready}, 32'd0);
      for (int i = 0; i < 2000; i++) begin
         if (rsp_valid) begin got = 1'b1; break; end
         @(negedge clk);
      end
      chk(got, {tag, " R5 result arrived"}, {31'd0, got}, 32'd1);
      chk(rsp_fault == exp_fault, {tag, " R5/R6/R7 fault flag"}, {31'd0, rsp_fault}, {31'd0, exp_fault});
      chk(rsp_ppn == exp_ppn, {tag, " R5 frame"}, {12'd0, rsp_ppn}, {12'd0, exp_ppn});
      chk(rsp_attr == exp_attr, {tag, " R5 attributes"}, {28'd0, rsp_attr}, {28'd0, exp_attr});
      chk(req_cnt - start == exp_reqs, {tag, " R6/R7 read count"}, 32'(req_cnt - start), 32'(exp_reqs));
      chk(req_log[start % 4] == a1, {tag, " R2 first read address"}, req_log[start % 4], a1);
      if (exp_reqs == 2)
         chk(req_log[(start + 1) % 4] == a2, {tag, " R4 second read address"}, req_log[(start + 1) % 4], a2);
      @(negedge clk);
      chk(!rsp_valid, {tag, " R5 single-cycle result"}, {31'd0, rsp_valid}, 32'd0);
      chk(miss_ready, {tag, " R11 ready again"}, {31'd0, miss_ready}, 32'd1);
   endtask

   task automatic write_base(input logic [31:0] b);
      @(negedge clk);
      base_wdata = b;
      base_wr = 1'b1;
      @(negedge clk);
      base_wr = 1'b0;
      chk(flush, "R9 flush after base write", {31'd0, flush}, 32'd1);
      @(negedge clk);
      chk(!flush, "R9 flush lasts one cycle", {31'd0, flush}, 32'd0);
   endtask

   task automatic t_reset;
      chk(miss_ready, "R1 miss_ready", {31'd0, miss_ready}, 32'd1);
      chk(!mem_req_valid, "R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
      chk(!rsp_valid, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk(!flush, "R1 flush", {31'd0, flush}, 32'd0);
   endtask

   task automatic t_normal;
      mem[32'h0001_000C] = pte(20'h00020, 4'h0, 1'b1);
      mem[32'h0002_0014] = pte(20'hABCDE, 4'hA, 1'b1);
      lat = 2; gap = 0;
      walk(32'h0001_0000, {10'd3, 10'd5}, 2, 20'hABCDE, 4'hA, 1'b0, "normal");
   endtask

   task automatic t_l1_fault;
      lat = 1;
      walk(32'h0001_0000, {10'd7, 10'd1}, 1, 20'h0, 4'h0, 1'b1, "l1 absent R6");
   endtask

   task automatic t_l2_fault;
      mem[32'h0001_0020] = pte(20'h00030, 4'h0, 1'b1);
      mem[32'h0003_0008] = pte(20'h55555, 4'hF, 1'b0);
      walk(32'h0001_0000, {10'd8, 10'd2}, 2, 20'h0, 4'h0, 1'b1, "l2 absent R7");
   endtask

   task automatic t_slow;
      mem[32'h0001_0FFC] = pte(20'h00044, 4'h0, 1'b1);
      mem[32'h0004_4FFC] = pte(20'hFFFFF, 4'h5, 1'b1);
      lat = 25; gap = 3;
      walk(32'h0001_0000, {10'd1023, 10'd1023}, 2, 20'hFFFFF, 4'h5, 1'b0, "slow top index R8");
      chk(overlap_err == 0, "R8 one read outstanding", 32'(overlap_err), 32'd0);
      chk(stab_err == 0, "R3 request held stable", 32'(stab_err), 32'd0);
      lat = 1; gap = 0;
   endtask

   task automatic t_new_base;
      write_base(32'h0005_0000);
      mem[32'h0005_000C] = pte(20'h00060, 4'h0, 1'b1);
      mem[32'h0006_0014] = pte(20'h12345, 4'h3, 1'b1);
      walk(32'h0005_0000, {10'd3, 10'd5}, 2, 20'h12345, 4'h3, 1'b0, "new base R9");
   endtask

   task automatic t_abort;
      int seen;
      int start;
      seen = rsp_cnt;
      lat = 10;
      start = req_cnt;
      @(negedge clk);
      miss_vpn = {10'd3, 10'd5};
      miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
      repeat (3) @(negedge clk);
      base_wdata = 32'h0001_0000;
      base_wr = 1'b1;
      @(negedge clk);
      base_wr = 1'b0;
      chk(flush, "R10 flush on abort", {31'd0, flush}, 32'd1);
      chk(!miss_ready, "R10 held off while read owed", {31'd0, miss_ready}, 32'd0);
      for (int i = 0; i < 50 && pend; i++) @(negedge clk);
      @(negedge clk);
      chk(miss_ready, "R10 ready after stale data", {31'd0, miss_ready}, 32'd1);
      chk(rsp_cnt == seen, "R10 no result for cancelled walk", 32'(rsp_cnt - seen), 32'd0);
      chk(req_cnt - start == 1, "R10 no further read", 32'(req_cnt - start), 32'd1);
      lat = 1;
      walk(32'h0001_0000, {10'd3, 10'd5}, 2, 20'hABCDE, 4'hA, 1'b0, "after abort R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      write_base(32'h0001_0000);
      t_normal;
      t_l1_fault;
      t_l2_fault;
      t_slow;
      t_new_base;
      t_abort;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > MAX_CYCLES) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cycles, MAX_CYCLES);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule